// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block gathers the data bytes of one write burst into a small page buffer and then copies them into a 128-byte memory during a single self-timed busy interval. A load strobe sets the target address. Each valid byte lands in the buffer slot named by a two-bit in-page pointer, and that pointer wraps inside the page. A burst longer than a page therefore overwrites the bytes it stored first, and the page row never changes.

A commit strobe starts the write cycle, provided the buffer holds at least one byte. For a fixed number of clock cycles, set by the `WR_CYCLES` parameter, the busy flag stays high. In the first page-size cycles of that interval the block drives one memory write for each slot that received a byte. Slots that received no byte are left alone in memory. An abort strobe discards the buffer. While busy is high, every strobe is ignored. The reset input is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, busy_o and mem_we_o are low, the buffer is empty, and the page and pointer are zero.
- R2: A load strobe takes the page row from addr_i[6:2] and the pointer from addr_i[1:0], and it empties the buffer.
- R3: Each accepted byte is stored at in-page slot `pointer`. Only the 2-bit pointer then advances by one, and the page row is unchanged.
- R4: From slot 3 the pointer moves to slot 0 of the same page.
- R5: When more than four bytes arrive after a load, each later byte replaces the earlier byte in the slot it wraps onto.
- R6: A commit accepted with a non-empty buffer raises busy_o on the next clock edge, and busy_o then stays high for exactly WR_CYCLES cycles.
- R7: In busy cycle k, for k from 0 to 3, the block asserts mem_we_o with mem_addr_o = {page, k} and the byte last stored in slot k, and only when slot k received a byte since the last load. No other memory writes occur.
- R8: An accepted abort empties the buffer and causes no memory write. A later commit then writes nothing.
- R9: A commit with an empty buffer causes no write and leaves busy_o low.
- R10: While busy_o is high, load, byte, commit and abort strobes have no effect. When the interval ends, the buffer is emptied and the page and pointer are kept.
- R11: Strobes that arrive in the same cycle are resolved in this order: abort first, then commit, then load, then byte. Only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Address load strobe |
| addr_i | input | 7 | Start address for load |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Start the timed write |
| abort_i | input | 1 | Discard the buffer |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 7 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The bench starts a burst in the middle of a page and also sends six bytes into one page. A pointer that carried into the page row would write to a neighbouring page, and a design without overwrite would keep the first bytes. A partial burst checks that the unfilled slots are never written. A design that wrote the whole page would be caught by an unexpected write that no queued item matches. Further cases pulse load, byte and abort during busy, commit an empty buffer, send abort together with commit, and send load together with byte. A design that dropped the busy gating or the strobe priority would write stale data, start a spurious busy interval, or lose the scheduled writes.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_BYTE,
    CMD_LOAD,
    CMD_COMMIT,
    CMD_ABORT
  } pce_cmd_e;

  // Strobe arbitration: nothing while busy, then abort > commit > load > byte (R10, R11)
  function automatic pce_cmd_e pce_decode(input logic busy, input logic abort,
                                          input logic commit, input logic load,
                                          input logic bytev);
    pce_cmd_e c;
    if (busy)        c = CMD_NONE;
    else if (abort)  c = CMD_ABORT;
    else if (commit) c = CMD_COMMIT;
    else if (load)   c = CMD_LOAD;
    else if (bytev)  c = CMD_BYTE;
    else             c = CMD_NONE;
    return c;
  endfunction

endpackage

// File: rtl/pce_addr_ctr.sv
module pce_addr_ctr #(
  parameter int ADDR_W = 7,
  parameter int PTR_W  = 2,
  localparam int PAGE_W = ADDR_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page_o,
  output logic [PTR_W-1:0]  ptr_o
);

  logic [PAGE_W-1:0] page_q, page_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              upd;

  assign upd = load_en | step_en;

  always_comb begin
    page_n = page_q;
    ptr_n  = ptr_q;
    if (load_en) begin
      page_n = addr[ADDR_W-1:PTR_W];
      ptr_n  = addr[PTR_W-1:0];
    end else if (step_en) begin
      ptr_n  = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
    end else if (upd) begin
      page_q <= page_n;
      ptr_q  <= ptr_n;
    end
  end

  assign page_o = page_q;
  assign ptr_o  = ptr_q;

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> $stable(page_q));

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && (&ptr_q)) |=> (ptr_q == '0));

endmodule

// File: rtl/pce_buffer.sv
module pce_buffer #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  localparam int PTR_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              clr_mask,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mark,
  output logic [PAGE_BYTES-1:0] mask_o
);

  logic [PAGE_BYTES-1:0][DATA_W-1:0] data_all;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] d_q, d_n;
    logic              m_q, m_n;
    logic              hit, en;

    assign hit = wr_en && (wr_slot == PTR_W'(i));
    assign en  = clr_all | clr_mask | hit;

    always_comb begin
      d_n = d_q;
      m_n = m_q;
      if (clr_all) begin
        d_n = '0;
        m_n = 1'b0;
      end else if (clr_mask) begin
        m_n = 1'b0;
      end else if (hit) begin
        d_n = wr_data;
        m_n = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        m_q <= 1'b0;
      end else if (en) begin
        d_q <= d_n;
        m_q <= m_n;
      end
    end

    assign data_all[i] = d_q;
    assign mask_o[i]   = m_q;
  end

  assign rd_data = data_all[rd_slot];
  assign rd_mark = mask_o[rd_slot];

  p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (mask_o == '0));

  p_fill_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all && !clr_mask) |=> mask_o[$past(wr_slot)]);

endmodule

// File: rtl/pce_commit_fsm.sv
module pce_commit_fsm #(
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 24,
  localparam int PTR_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy_o,
  output logic             slot_act_o,
  output logic [PTR_W-1:0] slot_o,
  output logic             done_o
);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLOTS = CNT_W'(PAGE_BYTES);

  st_e             st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_n  = ST_RUN;
        cnt_n = '0;
      end
      ST_RUN: if (cnt_q == LAST) begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy_o     = (st_q == ST_RUN);
  assign slot_act_o = busy_o && (cnt_q < SLOTS);
  assign slot_o     = cnt_q[PTR_W-1:0];
  assign done_o     = busy_o && (cnt_q == LAST);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == LAST));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> (busy_o && cnt_q == '0));

endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 24,
  localparam int PTR_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  import pce_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  pce_cmd_e              cmd;
  logic                  busy, slot_act, done, start, mark;
  logic [PAGE_W-1:0]     page;
  logic [PTR_W-1:0]      ptr, slot;
  logic [DATA_W-1:0]     rdata;
  logic [PAGE_BYTES-1:0] mask;

  assign cmd   = pce_decode(busy, abort_i, commit_i, load_i, byte_vld_i);
  assign start = (cmd == CMD_COMMIT) && (|mask);

  pce_addr_ctr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (cmd == CMD_LOAD),
    .step_en (cmd == CMD_BYTE),
    .addr    (addr_i),
    .page_o  (page),
    .ptr_o   (ptr)
  );

  pce_buffer #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (cmd == CMD_ABORT),
    .clr_mask ((cmd == CMD_LOAD) || done),
    .wr_en    (cmd == CMD_BYTE),
    .wr_slot  (ptr),
    .wr_data  (byte_i),
    .rd_slot  (slot),
    .rd_data  (rdata),
    .rd_mark  (mark),
    .mask_o   (mask)
  );

  pce_commit_fsm #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy_o     (busy),
    .slot_act_o (slot_act),
    .slot_o     (slot),
    .done_o     (done)
  );

  assign busy_o      = busy;
  assign mem_we_o    = slot_act && mark;
  assign mem_addr_o  = {page, slot};
  assign mem_wdata_o = rdata;

  p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_empty_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit_i && !abort_i && mask == '0) |=> !busy_o);

  p_busy_hold_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page));

  p_abort_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && abort_i) |=> (!busy_o && mask == '0));

endmodule

// File: tb/page_commit_engine_bench.sv
module page_commit_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 24;

  logic clk = 1'b0;
  logic rst_ni, load_i, byte_vld_i, commit_i, abort_i;
  logic [6:0] addr_i;
  logic [7:0] byte_i;
  logic busy_o, mem_we_o;
  logic [6:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_commit_engine #(.WR_CYCLES(WRC)) u_page_commit_engine (
    .clk(clk), .rst_ni(rst_ni), .load_i(load_i), .addr_i(addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i),
    .abort_i(abort_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  typedef struct { int a; int d; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit live = 1'b0, ended = 1'b0;

  int m_page, m_ptr;
  int m_data[4];
  bit m_mask[4];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pop one expected write for every write the design makes (R7)
  always @(negedge clk) begin
    if (live && mem_we_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R7 unexpected write addr", int'(mem_addr_o), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(mem_addr_o) == e.a, "R7 write addr", int'(mem_addr_o), e.a);
        check(int'(mem_wdata_o) == e.d, "R7 write data", int'(mem_wdata_o), e.d);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input int a);
    load_i = 1'b1; addr_i = 7'(a); tick(); load_i = 1'b0;
    m_page = a >> 2; m_ptr = a & 3;
    for (int k = 0; k < 4; k++) m_mask[k] = 1'b0;
  endtask

  task automatic do_byte(input int d);
    byte_vld_i = 1'b1; byte_i = 8'(d); tick(); byte_vld_i = 1'b0;
    m_data[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) & 3;
  endtask

  task automatic do_abort();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    for (int k = 0; k < 4; k++) begin m_mask[k] = 1'b0; m_data[k] = 0; end
  endtask

  // driver: queue the expected writes, strobe commit, measure busy (R6, R9, R10)
  task automatic do_commit(input bit poke, input string tag);
    bit any = 1'b0;
    int n = 0;
    for (int k = 0; k < 4; k++)
      if (m_mask[k]) begin
        exp_t e;
        e.a = m_page * 4 + k; e.d = m_data[k];
        q.push_back(e); any = 1'b1;
      end
    commit_i = 1'b1; tick(); commit_i = 1'b0;
    if (!any) begin
      check(busy_o == 1'b0, {tag, " R9 busy stays low"}, int'(busy_o), 0);
      tick();
      check(busy_o == 1'b0, {tag, " R9 busy still low"}, int'(busy_o), 0);
    end else begin
      check(busy_o == 1'b1, {tag, " R6 busy rises"}, int'(busy_o), 1);
      while (busy_o && n < 4 * WRC) begin
        if (poke) begin
          load_i = (n == 0); addr_i = 7'h00;
          byte_vld_i = (n == 1); byte_i = 8'hEE;
          abort_i = (n == 2); commit_i = (n == 3);
        end
        n++;
        tick();
      end
      load_i = 1'b0; byte_vld_i = 1'b0; abort_i = 1'b0; commit_i = 1'b0;
      check(n == WRC, {tag, " R6 busy length"}, n, WRC);
      check(q.size() == 0, {tag, " R7 all writes seen"}, q.size(), 0);
    end
    for (int k = 0; k < 4; k++) m_mask[k] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; load_i = 1'b0; byte_vld_i = 1'b0; commit_i = 1'b0;
    abort_i = 1'b0; addr_i = '0; byte_i = '0;
    m_page = 0; m_ptr = 0;
    for (int k = 0; k < 4; k++) begin m_mask[k] = 1'b0; m_data[k] = 0; end
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (4) tick();
    live = 1'b1;
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    check(mem_we_o == 1'b0, "R1 no write after reset", int'(mem_we_o), 0);
    // R1 pointer 0 page 0: byte without load goes to address 0
    do_byte(8'h3C);
    do_commit(1'b0, "R1 default address");

    // R2 R3 single byte
    do_load(7'h13); do_byte(8'hA5);
    do_commit(1'b0, "R2 R3 byte write");

    // R4 mid-page start wraps to slot 0 of the same page
    do_load(7'h26);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'h44);
    do_commit(1'b0, "R4 wrap");

    // R5 six bytes overwrite slots 0 and 1
    do_load(7'h40);
    for (int i = 1; i <= 6; i++) do_byte(i);
    do_commit(1'b0, "R5 overwrite");

    // R7 partial page, R10 strobes during busy ignored
    do_load(7'h7D); do_byte(8'hC1); do_byte(8'hC2);
    do_commit(1'b1, "R7 R10 partial");
    do_commit(1'b0, "R10 buffer emptied");
    // R10 pointer and page kept: next byte goes to 0x7F
    do_byte(8'h9C);
    do_commit(1'b0, "R10 address kept");

    // R8 abort
    do_load(7'h08); do_byte(8'h55); do_byte(8'h66);
    do_abort();
    do_commit(1'b0, "R8 abort");

    // R9 empty commit right after a load
    do_load(7'h50);
    do_commit(1'b0, "R9 empty");

    // R2 load empties earlier bytes
    do_load(7'h10); do_byte(8'hAA);
    do_load(7'h51); do_byte(8'hBB);
    do_commit(1'b0, "R2 load clears");

    // R11 abort beats commit
    do_load(7'h0C); do_byte(8'h5A);
    abort_i = 1'b1; commit_i = 1'b1; tick(); abort_i = 1'b0; commit_i = 1'b0;
    for (int k = 0; k < 4; k++) m_mask[k] = 1'b0;
    check(busy_o == 1'b0, "R11 abort over commit", int'(busy_o), 0);
    do_commit(1'b0, "R11 after abort");

    // R11 load beats byte in the same cycle
    load_i = 1'b1; addr_i = 7'h60; byte_vld_i = 1'b1; byte_i = 8'h12;
    tick(); load_i = 1'b0; byte_vld_i = 1'b0;
    m_page = 7'h60 >> 2; m_ptr = 0;
    for (int k = 0; k < 4; k++) m_mask[k] = 1'b0;
    do_byte(8'h34);
    do_commit(1'b0, "R11 load over byte");

    repeat (3) tick();
    check(q.size() == 0, "R7 queue drained", q.size(), 0);
    finish_run();
  end
endmodule